// File: doc/BRIEF.md
# Accelerator Core Run Control Unit

This block sits next to a processor core and decides whether that core runs, is frozen, or is held in software reset. A host reaches it through a simple 32-bit register port with a write enable, a byte address and a combinational read-data return. Through this port the host manages four interrupt sources: host request, finish, instruction fault and data fault. It can also write a control word. The two low bits of that word select the core mode, and the remaining bits up to bit 18 give the boot start offset.

The core reports three events to the block: a host request, a finish and a data fault. Each event is a single-cycle input. An event rewrites the mode directly and marks its interrupt as pending. The block drives a registered halt line to the core. When the software-reset bit is released, the block issues a one-cycle core reset pulse and, in the same cycle, a start-PC value with a load strobe. The start PC is a configurable base address plus the word-aligned start offset.

Top module: `core_run_ctrl`

## Requirements
- R1: After reset, halt is 1, the control word reads 0x3, the interrupt pending and enable registers read 0, and all four interrupt lines, the core reset pulse and the PC load strobe are 0.
- R2: A write to the pending-state register (offset 0x00) clears each pending bit whose write-data bit is 1 and leaves every other pending bit unchanged.
- R3: A write to the test register (offset 0x08) sets the pending bits written as 1. A write to the enable register (offset 0x04) replaces all four enable bits with write-data bits [3:0]. Reads of 0x04 return the enable mask.
- R4: Interrupt line i equals pending bit i AND enable bit i, with bit 0 = host request, 1 = finish, 2 = instruction fault and 3 = data fault.
- R5: The control register (offset 0x0C) stores write-data bits [18:0] and reads them back, with bits 31:19 reading 0. Bit 0 is freeze and bit 1 is software reset, and the core runs only when both are 0.
- R6: The halt output is registered. From the clock edge that updates the mode, it is 1 when the new mode is not run and 0 when it is run.
- R7: When the software-reset bit goes from 1 to 0, the core reset output and the PC load strobe are both 1 for exactly one cycle, starting at the updating edge. The start PC is then BOOT_BASE + (control[18:0] with bits [1:0] cleared).
- R8: A host-request event sets the mode to freeze only (0b01) and sets pending bit 0.
- R9: A finish event or a data-fault event sets the mode to freeze plus software reset (0b11) and sets pending bit 1 or bit 3 respectively. When either arrives together with a host request, the mode becomes 0b11.
- R10: An event in the same cycle as a host write wins: a control write is dropped, and a pending bit set by the event stays set even when the state write clears it.
- R11: Offset 0x08 reads 0. Every offset other than 0x00, 0x04, 0x08 and 0x0C, including unaligned ones, reads 0 and ignores writes.
- R12: No reset pulse or PC load occurs when the software-reset bit stays 0, stays 1 or rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for reg_addr |
| ev_host_req | input | 1 | Single-cycle host-request event from the core |
| ev_finish | input | 1 | Single-cycle finish event from the core |
| ev_data_fault | input | 1 | Single-cycle data-fault event from the core |
| halt_o | output | 1 | Core halt |
| core_rst_o | output | 1 | One-cycle core reset pulse |
| pc_load_o | output | 1 | One-cycle start-PC load strobe |
| start_pc_o | output | PC_W | Start PC value |
| irq_o | output | 4 | Gated interrupt lines |

## Verification
The bench keeps the default widths and overrides BOOT_BASE to 0x0004_0000. With that base, a start offset of 0x7FFFC must give 0x000BFFFC, so the offset field's full width is checked against the adder. Because the start field is the full 19 bits, a control write of all ones can show both the masking of bits 31:19 and the clearing of the two mode bits in the start PC. The bench runs every mode transition (run, freeze, software reset, and both together) through host writes and through events. This covers each edge of the software-reset bit and each collision between an event and a write.

// File: rtl/run_ctrl_pkg.sv
// Package: shared constants for the core run control unit.
// Assumes a word-addressed register space decoded on full byte addresses.
package run_ctrl_pkg;
    localparam int IRQ_N     = 4;
    localparam int IRQ_HOST  = 0;
    localparam int IRQ_FIN   = 1;
    localparam int IRQ_IFLT  = 2;
    localparam int IRQ_DFLT  = 3;

    localparam logic [1:0] MODE_RUN    = 2'b00;
    localparam logic [1:0] MODE_FREEZE = 2'b01;
    localparam logic [1:0] MODE_HOLD   = 2'b11;

    localparam int OFS_STATE  = 'h00;
    localparam int OFS_ENABLE = 'h04;
    localparam int OFS_TEST   = 'h08;
    localparam int OFS_CTRL   = 'h0C;
endpackage

// File: rtl/irq_unit.sv
// Module: interrupt pending/enable storage with gated outputs.
// Assumes at most one of state_we/test_we is high per cycle (one address).
// Events set pending bits and override a same-cycle clear.
module irq_unit #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         state_we,
    input  logic         test_we,
    input  logic         enable_we,
    input  logic [N-1:0] wdata,
    input  logic [N-1:0] ev_set,
    output logic [N-1:0] pend_o,
    output logic [N-1:0] en_o,
    output logic [N-1:0] irq_o
);
    logic [N-1:0] pend_q, en_q, clr_mask, set_mask;

    // Purpose: build the clear and set masks for this cycle.
    always_comb begin
        clr_mask = state_we ? wdata : '0;
        set_mask = (test_we ? wdata : '0) | ev_set;
    end

    // Purpose: update pending and enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            en_q   <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_mask) | set_mask;
            if (enable_we) en_q <= wdata;
        end
    end

    assign pend_o = pend_q;
    assign en_o   = en_q;
    assign irq_o  = pend_q & en_q;

    for (genvar i = 0; i < N; i++) begin : g_chk
        assert_event_sets_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ev_set[i] |=> pend_o[i]);
        assert_state_write_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (state_we && wdata[i] && !ev_set[i]) |=> !pend_o[i]);
    end
endmodule

// File: rtl/mode_unit.sv
// Module: control word, run mode, halt, core reset pulse and start PC.
// Assumes events outrank a same-cycle control write; finish/fault
// outrank host request. Reset pulse fires on software-reset 1->0.
module mode_unit
    import run_ctrl_pkg::*;
#(
    parameter int               START_W   = 19,
    parameter int               PC_W      = 32,
    parameter logic [PC_W-1:0]  BOOT_BASE = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_we,
    input  logic [START_W-1:0] wdata,
    input  logic               ev_host,
    input  logic               ev_stop,
    output logic [START_W-1:0] ctrl_o,
    output logic               halt_o,
    output logic               core_rst_o,
    output logic               pc_load_o,
    output logic [PC_W-1:0]    pc_o
);
    localparam logic [START_W-1:0] CTRL_RST = START_W'(MODE_HOLD);

    logic [START_W-1:0] ctrl_q, ctrl_next;
    logic               halt_q, rst_q, srst_fall;
    logic [PC_W-1:0]    pc_q, pc_next;

    // Purpose: choose the next control word with event priority.
    always_comb begin
        ctrl_next = ctrl_q;
        if (ev_stop)      ctrl_next[1:0] = MODE_HOLD;
        else if (ev_host) ctrl_next[1:0] = MODE_FREEZE;
        else if (ctrl_we) ctrl_next = wdata;
        srst_fall = ctrl_q[1] & ~ctrl_next[1];
        pc_next   = BOOT_BASE + PC_W'({ctrl_next[START_W-1:2], 2'b00});
    end

    // Purpose: register control word, halt, reset pulse and start PC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
            halt_q <= 1'b1;
            rst_q  <= 1'b0;
            pc_q   <= BOOT_BASE;
        end else begin
            ctrl_q <= ctrl_next;
            halt_q <= (ctrl_next[1:0] != MODE_RUN);
            rst_q  <= srst_fall;
            if (srst_fall) pc_q <= pc_next;
        end
    end

    assign ctrl_o     = ctrl_q;
    assign halt_o     = halt_q;
    assign core_rst_o = rst_q;
    assign pc_load_o  = rst_q;
    assign pc_o       = pc_q;

    assert_reset_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_o |=> !core_rst_o);
    assert_stop_event_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> (ctrl_o[1:0] == MODE_HOLD) && halt_o);
    assert_host_event_freezes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_host && !ev_stop) |=> (ctrl_o[1:0] == MODE_FREEZE) && halt_o);
    assert_halt_tracks_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o == (ctrl_o[1:0] != MODE_RUN));
endmodule

// File: rtl/core_run_ctrl.sv
// Module: top of the core run control unit. Decodes the register port,
// returns read data combinationally and routes core events.
// Assumes full-address decode; unmapped offsets read zero.
module core_run_ctrl
    import run_ctrl_pkg::*;
#(
    parameter int               ADDR_W    = 12,
    parameter int               DATA_W    = 32,
    parameter int               START_W   = 19,
    parameter int               PC_W      = 32,
    parameter logic [PC_W-1:0]  BOOT_BASE = 32'h0001_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ev_host_req,
    input  logic              ev_finish,
    input  logic              ev_data_fault,
    output logic              halt_o,
    output logic              core_rst_o,
    output logic              pc_load_o,
    output logic [PC_W-1:0]   start_pc_o,
    output logic [IRQ_N-1:0]  irq_o
);
    logic               hit_state, hit_enable, hit_test, hit_ctrl;
    logic [IRQ_N-1:0]   ev_set, pend, en;
    logic [START_W-1:0] ctrl;

    // Purpose: decode register hits from the byte address.
    always_comb begin
        hit_state  = (reg_addr == ADDR_W'(OFS_STATE));
        hit_enable = (reg_addr == ADDR_W'(OFS_ENABLE));
        hit_test   = (reg_addr == ADDR_W'(OFS_TEST));
        hit_ctrl   = (reg_addr == ADDR_W'(OFS_CTRL));
    end

    // Purpose: map core events onto pending bit positions.
    always_comb begin
        ev_set           = '0;
        ev_set[IRQ_HOST] = ev_host_req;
        ev_set[IRQ_FIN]  = ev_finish;
        ev_set[IRQ_DFLT] = ev_data_fault;
    end

    irq_unit #(.N(IRQ_N)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_we  (reg_we && hit_state),
        .test_we   (reg_we && hit_test),
        .enable_we (reg_we && hit_enable),
        .wdata     (reg_wdata[IRQ_N-1:0]),
        .ev_set    (ev_set),
        .pend_o    (pend),
        .en_o      (en),
        .irq_o     (irq_o)
    );

    mode_unit #(.START_W(START_W), .PC_W(PC_W), .BOOT_BASE(BOOT_BASE)) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (reg_we && hit_ctrl),
        .wdata      (reg_wdata[START_W-1:0]),
        .ev_host    (ev_host_req),
        .ev_stop    (ev_finish || ev_data_fault),
        .ctrl_o     (ctrl),
        .halt_o     (halt_o),
        .core_rst_o (core_rst_o),
        .pc_load_o  (pc_load_o),
        .pc_o       (start_pc_o)
    );

    // Purpose: return read data for the addressed register.
    always_comb begin
        reg_rdata = '0;
        if (hit_state)  reg_rdata = DATA_W'(pend);
        if (hit_enable) reg_rdata = DATA_W'(en);
        if (hit_ctrl)   reg_rdata = DATA_W'(ctrl);
    end

    assert_pc_load_with_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |-> core_rst_o && !$past(ctrl[1] == 1'b0));
    assert_unmapped_reads_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_state || hit_enable || hit_ctrl) |-> (reg_rdata == '0));
endmodule

// File: tb/test_core_run_ctrl.sv
`timescale 1ns/1ps
module test_core_run_ctrl;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int PC_W   = 32;
    localparam logic [PC_W-1:0] BASE = 32'h0004_0000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_we = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              ev_host_req = 1'b0, ev_finish = 1'b0, ev_data_fault = 1'b0;
    logic              halt_o, core_rst_o, pc_load_o;
    logic [PC_W-1:0]   start_pc_o;
    logic [3:0]        irq_o;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    core_run_ctrl #(.BOOT_BASE(BASE)) i_core_run_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_host_req(ev_host_req), .ev_finish(ev_finish), .ev_data_fault(ev_data_fault),
        .halt_o(halt_o), .core_rst_o(core_rst_o), .pc_load_o(pc_load_o),
        .start_pc_o(start_pc_o), .irq_o(irq_o)
    );

    // Vector: {we, addr, wdata, expected read}
    localparam int NV = 18;
    localparam logic [76:0] VEC [NV] = '{
        {1'b0, 12'h00C, 32'h0,         32'h3},      // R1 control reset value
        {1'b0, 12'h000, 32'h0,         32'h0},      // R1 pending clear
        {1'b1, 12'h004, 32'hF,         32'h0},
        {1'b0, 12'h004, 32'h0,         32'hF},      // R3 enable readback
        {1'b1, 12'h008, 32'h5,         32'h0},
        {1'b0, 12'h000, 32'h0,         32'h5},      // R3 test sets pending
        {1'b0, 12'h008, 32'h0,         32'h0},      // R11 test reads zero
        {1'b1, 12'h000, 32'h1,         32'h0},
        {1'b0, 12'h000, 32'h0,         32'h4},      // R2 clear bit 0 only
        {1'b1, 12'h004, 32'hFFFF_FFF2, 32'h0},
        {1'b0, 12'h004, 32'h0,         32'h2},      // R3 enable replaced
        {1'b1, 12'h010, 32'hFFFF,      32'h0},
        {1'b0, 12'h010, 32'h0,         32'h0},      // R11 unmapped
        {1'b1, 12'h00C, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 12'h00C, 32'h0,         32'h7FFFF},  // R5 19-bit field
        {1'b0, 12'h00E, 32'h0,         32'h0},      // R11 unaligned
        {1'b1, 12'h000, 32'hF,         32'h0},
        {1'b0, 12'h000, 32'h0,         32'h0}       // R2 clear all
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic ev(input logic h, input logic f, input logic x);
        @(negedge clk);
        ev_host_req = h; ev_finish = f; ev_data_fault = x;
        @(negedge clk);
        ev_host_req = 1'b0; ev_finish = 1'b0; ev_data_fault = 1'b0;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset outputs
        check("R1 halt", 32'(halt_o), 32'h1);
        check("R1 irq", 32'(irq_o), 32'h0);
        check("R1 core reset", 32'(core_rst_o), 32'h0);
        check("R1 pc load", 32'(pc_load_o), 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][76]) begin
                wr(VEC[i][75:64], VEC[i][63:32]);
            end else begin
                rd(VEC[i][75:64], v);
                check($sformatf("table entry %0d", i), v, VEC[i][31:0]);
            end
        end

        // R7 software reset release with maximum start offset
        wr(12'h00C, 32'h7FFFC);
        check("R7 reset pulse", 32'(core_rst_o), 32'h1);
        check("R7 pc load", 32'(pc_load_o), 32'h1);
        check("R7 start pc", start_pc_o, 32'h000B_FFFC);
        check("R6 halt released", 32'(halt_o), 32'h0);
        @(negedge clk);
        check("R7 pulse one cycle", 32'(core_rst_o), 32'h0);
        check("R7 load one cycle", 32'(pc_load_o), 32'h0);

        // R12 rising software reset: no pulse
        wr(12'h00C, 32'h2);
        check("R12 no pulse on rise", 32'(core_rst_o), 32'h0);
        check("R6 halt in swreset", 32'(halt_o), 32'h1);
        check("R12 pc kept", start_pc_o, 32'h000B_FFFC);
        wr(12'h00C, 32'h1);
        check("R7 pulse to freeze", 32'(pc_load_o), 32'h1);
        check("R7 pc base", start_pc_o, BASE);
        check("R6 halt frozen", 32'(halt_o), 32'h1);
        wr(12'h00C, 32'h0);
        check("R12 no pulse 0 to 0", 32'(core_rst_o), 32'h0);
        check("R6 run", 32'(halt_o), 32'h0);

        // R8 host request event
        wr(12'h004, 32'hF);
        wr(12'h000, 32'hF);
        ev(1'b1, 1'b0, 1'b0);
        rd(12'h00C, v); check("R8 mode freeze", v, 32'h1);
        check("R8 halt", 32'(halt_o), 32'h1);
        rd(12'h000, v); check("R8 pending bit0", v, 32'h1);
        check("R4 irq host", 32'(irq_o), 32'h1);

        // R9 finish and data fault events
        wr(12'h00C, 32'h0);
        check("R6 run again", 32'(halt_o), 32'h0);
        ev(1'b0, 1'b1, 1'b0);
        rd(12'h00C, v); check("R9 finish mode", v, 32'h3);
        check("R9 halt", 32'(halt_o), 32'h1);
        rd(12'h000, v); check("R9 finish pending", v, 32'h3);
        wr(12'h00C, 32'h0);
        ev(1'b0, 1'b0, 1'b1);
        rd(12'h00C, v); check("R9 fault mode", v, 32'h3);
        rd(12'h000, v); check("R9 fault pending", v, 32'hB);
        wr(12'h00C, 32'h0);
        wr(12'h000, 32'hF);
        ev(1'b1, 1'b1, 1'b0);
        rd(12'h00C, v); check("R9 finish beats host", v, 32'h3);
        rd(12'h000, v); check("R9 both pending", v, 32'h3);

        // R10 event beats same-cycle host writes
        wr(12'h00C, 32'h0);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 12'h00C; reg_wdata = 32'h0; ev_host_req = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; ev_host_req = 1'b0;
        rd(12'h00C, v); check("R10 control write dropped", v, 32'h1);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 12'h000; reg_wdata = 32'h2; ev_finish = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; ev_finish = 1'b0;
        rd(12'h000, v); check("R10 pending kept", v, 32'h3);
        rd(12'h00C, v); check("R10 finish mode", v, 32'h3);

        // R4 gating per line
        wr(12'h000, 32'hF);
        wr(12'h004, 32'hA);
        wr(12'h008, 32'hF);
        check("R4 irq enable A", 32'(irq_o), 32'hA);
        wr(12'h004, 32'h5);
        check("R4 irq enable 5", 32'(irq_o), 32'h5);
        wr(12'h000, 32'h4);
        check("R4 irq after clear bit2", 32'(irq_o), 32'h1);

        summary();
        $finish;
    end
endmodule